// File: doc/BRIEF.md
# Multichannel ADC Serial Control Port

This block is the digital side of a 16-channel sampling converter: its serial port and its mode control. A frame opens when chip select goes low. During the frame the block takes a 16-bit word in on the data input. It uses that word to update a 12-bit control register or a channel-enable mask. At the same time it shifts out the address of the channel being converted, followed by that channel's 12-bit result. The result arrives on a parallel port from the surrounding logic. The block also drives a track/hold indication and a power state with a ready flag.

The chip-select, serial-clock and data inputs come from outside the system clock domain. Each passes through a two-stage synchroniser before edge detection. The power-up delay and the minimum idle time between frames are parameters counted in system clock cycles.

Top module: `adc_serial_port`

## Requirements
- R1: A falling edge of csN starts a frame. holdOut goes to 1, and dout presents the most significant bit of the channel address before the first serial clock.
- R2: The control word is the first 12 bits of the frame, first bit in bit 11. The layout is: bit 11 write, bit 10 sequence, bits 9..6 address, bits 5..4 power mode, bit 3 mask-load, bit 2 keep-driving, bit 1 range, bit 0 coding. The register takes the word at the 12th falling serial clock only when bit 11 is 1. Otherwise ctrlReg is unchanged.
- R3: After a frame that wrote sequence=0 and mask-load=1, the next frame's 16 bits load shadowReg, with the first bit landing in bit 15. Bit k enables channel k. That frame leaves ctrlReg unchanged even if its first bit is 1.
- R4: dout carries the 4-bit channel address and then the 12-bit conversion result, MSB first. Each bit changes on a falling serial clock. din is sampled on the same falling edge.
- R5: holdOut returns to 0 on the 14th falling serial clock of the frame.
- R6: doutEn is 1 while a frame is open. After csN rises it stays 1 only if the keep-driving bit is 1, and otherwise drops to 0.
- R7: A frame that ends with power mode 10 in ctrlReg puts the block in shutdown: pwrDown=1 and pwrReady=0. ctrlReg keeps its contents.
- R8: A frame that ends in shutdown with a power mode other than 10 starts a wake-up. pwrReady returns to 1 only after PWRUP_CYC cycles. A csN fall during the wake-up pulses pwrErr.
- R9: A csN fall less than QUIET_CYC cycles after the previous csN rise pulses quietErr. A later csN fall does not.
- R10: A write with sequence=1 and mask-load=0 selects the lowest enabled channel for the next frame. Each later full frame without a write advances to the next enabled channel in ascending order, wrapping to the lowest after the highest.
- R11: A write with sequence=0 makes the next frame convert the written address.
- R12: After reset the block is powered and ready. holdOut=0, doutEn=0, ctrlReg=0x030 (power mode 11), shadowReg=0 and curChan=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| din | input | 1 | Serial data in |
| convResult | input | RES_W | Conversion result for the current channel |
| dout | output | 1 | Serial data out |
| doutEn | output | 1 | Output driver enable (0 = high impedance) |
| holdOut | output | 1 | 1 = hold, 0 = track |
| pwrReady | output | 1 | Fully powered |
| pwrDown | output | 1 | In shutdown |
| pwrErr | output | 1 | One-cycle pulse: frame started during wake-up |
| quietErr | output | 1 | One-cycle pulse: frame started inside the quiet time |
| ctrlReg | output | 12 | Control register |
| shadowReg | output | NUM_CH | Channel enable mask |
| curChan | output | ADDR_W | Channel for the next frame |

## Verification
The hardest state to reach is an error-free wake-up followed by a violated one. The block must first be taken into shutdown by one frame and brought back out by a second. Only then can a third frame land inside the power-up window. The bench chains exactly those frames with a short gap and follows them with an even shorter gap, which also trips the quiet-time check. The sequence wrap needs a mask whose top channel is enabled, so the stimulus loads a mask that includes both channel 15 and a low channel before stepping through it.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  localparam int CTRL_W     = 12;
  localparam int CB_WRITE   = 11;
  localparam int CB_SEQ     = 10;
  localparam int CB_ADD_HI  = 9;
  localparam int CB_ADD_LO  = 6;
  localparam int CB_PM_HI   = 5;
  localparam int CB_PM_LO   = 4;
  localparam int CB_SHADOW  = 3;
  localparam int CB_WEAK    = 2;
  localparam int CB_RANGE   = 1;
  localparam int CB_CODING  = 0;
  localparam int TRACK_EDGE = 14;
  localparam logic [1:0]        PM_OFF   = 2'b10;
  localparam logic [CTRL_W-1:0] CTRL_RST = 12'h030;

  typedef enum logic [1:0] {PWR_ON, PWR_OFF, PWR_WAKE} pwrState_t;

  typedef struct packed {
    logic frameStart;
    logic sample;
    logic ctrlBit;
    logic lastBit;
    logic frameEnd;
    logic frameFull;
  } portStb_t;
endpackage

// File: rtl/adc_port_ctrl.sv
module adc_port_ctrl
  import adc_port_pkg::*;
#(
  parameter int FRAME_W   = 16,
  parameter int PWRUP_CYC = 200,
  parameter int QUIET_CYC = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       din,
  input  logic [1:0] pmIn,
  output portStb_t   stb,
  output logic       dinS,
  output logic       frameActive,
  output logic       holdOut,
  output logic       pwrReady,
  output logic       pwrDown,
  output logic       pwrErr,
  output logic       quietErr
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam int PWR_W = $clog2(PWRUP_CYC + 1);
  localparam int Q_W   = $clog2(QUIET_CYC + 1);

  logic [1:0] csSync, sclkSync, dinSync;
  logic csPrev, sclkPrev;
  logic csFall, csRise, sclkFall;
  logic [CNT_W-1:0] bitCnt;
  logic [PWR_W-1:0] wakeCnt;
  logic [Q_W-1:0]   quietCnt;
  pwrState_t pwrState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync   <= 2'b11;
      sclkSync <= 2'b00;
      dinSync  <= 2'b00;
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csSync   <= {csSync[0], csN};
      sclkSync <= {sclkSync[0], sclk};
      dinSync  <= {dinSync[0], din};
      csPrev   <= csSync[1];
      sclkPrev <= sclkSync[1];
    end
  end

  assign dinS     = dinSync[1];
  assign csFall   = csPrev & ~csSync[1];
  assign csRise   = ~csPrev & csSync[1];
  assign sclkFall = sclkPrev & ~sclkSync[1];

  always_comb begin
    stb.frameStart = csFall;
    stb.sample     = frameActive & sclkFall & (bitCnt < CNT_W'(FRAME_W));
    stb.ctrlBit    = stb.sample & (bitCnt == CNT_W'(CTRL_W - 1));
    stb.lastBit    = stb.sample & (bitCnt == CNT_W'(FRAME_W - 1));
    stb.frameEnd   = csRise & frameActive;
    stb.frameFull  = (bitCnt == CNT_W'(FRAME_W));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameActive <= 1'b0;
      bitCnt      <= '0;
      holdOut     <= 1'b0;
    end else begin
      if (csFall) begin
        frameActive <= 1'b1;
        bitCnt      <= '0;
        holdOut     <= 1'b1;
      end else begin
        if (csRise) frameActive <= 1'b0;
        if (stb.sample) begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == CNT_W'(TRACK_EDGE - 1)) holdOut <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrState <= PWR_ON;
      wakeCnt  <= '0;
    end else if (stb.frameEnd) begin
      if (pmIn == PM_OFF) begin
        pwrState <= PWR_OFF;
      end else if (pwrState == PWR_OFF) begin
        pwrState <= PWR_WAKE;
        wakeCnt  <= PWR_W'(PWRUP_CYC);
      end
    end else if (pwrState == PWR_WAKE) begin
      if (wakeCnt == '0) pwrState <= PWR_ON;
      else               wakeCnt  <= wakeCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quietCnt <= '0;
      pwrErr   <= 1'b0;
      quietErr <= 1'b0;
    end else begin
      pwrErr   <= csFall & (pwrState == PWR_WAKE);
      quietErr <= csFall & (quietCnt != '0);
      if (stb.frameEnd)         quietCnt <= Q_W'(QUIET_CYC);
      else if (quietCnt != '0)  quietCnt <= quietCnt - 1'b1;
    end
  end

  assign pwrReady = (pwrState == PWR_ON);
  assign pwrDown  = (pwrState == PWR_OFF);

  a_r5_track_edge: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdOut) |-> bitCnt == CNT_W'(TRACK_EDGE));
  a_r4_bits_bounded: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(FRAME_W));
  a_r7_shutdown: assert property (@(posedge clk) disable iff (!rstN)
    stb.frameEnd && pmIn == PM_OFF |=> pwrDown);
  a_r8_ready_after_wake: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwrReady) |-> $past(pwrState) == PWR_WAKE);
endmodule

// File: rtl/adc_port_dp.sv
module adc_port_dp
  import adc_port_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int RES_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStb_t          stb,
  input  logic              dinS,
  input  logic [RES_W-1:0]  convResult,
  output logic              dout,
  output logic [CTRL_W-1:0] ctrlReg,
  output logic [NUM_CH-1:0] shadowReg,
  output logic [$clog2(NUM_CH)-1:0] curChan
);
  localparam int ADDR_W  = $clog2(NUM_CH);
  localparam int FRAME_W = ADDR_W + RES_W;

  logic [FRAME_W-1:0] shiftIn, shiftOut, newWord;
  logic shadowArm, shadowFrame, wroteThis;
  logic seqMode;
  logic [ADDR_W-1:0] firstEn, nextEn, cand, addrField;
  logic foundFirst, foundNext;

  assign newWord   = {shiftIn[FRAME_W-2:0], dinS};
  assign dout      = shiftOut[FRAME_W-1];
  assign seqMode   = ctrlReg[CB_SEQ] & ~ctrlReg[CB_SHADOW];
  assign addrField = ADDR_W'(ctrlReg[CB_ADD_HI:CB_ADD_LO]);

  always_comb begin
    firstEn    = '0;
    foundFirst = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (!foundFirst && shadowReg[i]) begin
        firstEn    = ADDR_W'(i);
        foundFirst = 1'b1;
      end
    end
    nextEn    = curChan;
    foundNext = 1'b0;
    cand      = curChan;
    for (int i = 1; i <= NUM_CH; i++) begin
      cand = curChan + ADDR_W'(i);
      if (!foundNext && shadowReg[cand]) begin
        nextEn    = cand;
        foundNext = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftIn  <= '0;
      shiftOut <= '0;
    end else if (stb.frameStart) begin
      shiftIn  <= '0;
      shiftOut <= {curChan, convResult};
    end else if (stb.sample) begin
      shiftIn  <= newWord;
      shiftOut <= {shiftOut[FRAME_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg     <= CTRL_RST;
      shadowReg   <= '0;
      shadowArm   <= 1'b0;
      shadowFrame <= 1'b0;
      wroteThis   <= 1'b0;
      curChan     <= '0;
    end else begin
      if (stb.frameStart) begin
        wroteThis   <= 1'b0;
        shadowFrame <= shadowArm;
        shadowArm   <= 1'b0;
      end
      if (stb.ctrlBit && !shadowFrame && newWord[CB_WRITE]) begin
        ctrlReg   <= newWord[CTRL_W-1:0];
        wroteThis <= 1'b1;
        if (!newWord[CB_SEQ] && newWord[CB_SHADOW]) shadowArm <= 1'b1;
      end
      if (stb.lastBit && shadowFrame) shadowReg <= NUM_CH'(newWord);
      if (stb.frameEnd && stb.frameFull) begin
        if (wroteThis)    curChan <= seqMode ? firstEn : addrField;
        else if (seqMode) curChan <= nextEn;
      end
    end
  end

  a_r2_ctrl_stable: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ctrlBit |=> $stable(ctrlReg));
  a_r4_dout_stable: assert property (@(posedge clk) disable iff (!rstN)
    !stb.sample && !stb.frameStart |=> $stable(dout));
  a_r10_seq_enabled: assert property (@(posedge clk) disable iff (!rstN)
    stb.frameEnd && stb.frameFull && seqMode && !wroteThis && (shadowReg != '0)
      |=> shadowReg[curChan]);
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_port_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int RES_W     = 12,
  parameter int PWRUP_CYC = 200,
  parameter int QUIET_CYC = 20,
  localparam int ADDR_W   = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              din,
  input  logic [RES_W-1:0]  convResult,
  output logic              dout,
  output logic              doutEn,
  output logic              holdOut,
  output logic              pwrReady,
  output logic              pwrDown,
  output logic              pwrErr,
  output logic              quietErr,
  output logic [11:0]       ctrlReg,
  output logic [NUM_CH-1:0] shadowReg,
  output logic [ADDR_W-1:0] curChan
);
  localparam int FRAME_W = ADDR_W + RES_W;

  portStb_t stb;
  logic dinS, frameActive;

  adc_port_ctrl #(
    .FRAME_W(FRAME_W), .PWRUP_CYC(PWRUP_CYC), .QUIET_CYC(QUIET_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .pmIn(ctrlReg[CB_PM_HI:CB_PM_LO]), .stb(stb), .dinS(dinS),
    .frameActive(frameActive), .holdOut(holdOut), .pwrReady(pwrReady),
    .pwrDown(pwrDown), .pwrErr(pwrErr), .quietErr(quietErr)
  );

  adc_port_dp #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .dinS(dinS), .convResult(convResult),
    .dout(dout), .ctrlReg(ctrlReg), .shadowReg(shadowReg), .curChan(curChan)
  );

  assign doutEn = frameActive | ctrlReg[CB_WEAK];

  a_r6_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(doutEn) |-> !ctrlReg[CB_WEAK]);
endmodule

// File: tb/adc_serial_port_tb.sv
module adc_serial_port_tb;
  logic clk = 1'b0;
  logic rstN, csN, sclk, din;
  logic [11:0] convResult;
  logic dout, doutEn, holdOut, pwrReady, pwrDown, pwrErr, quietErr;
  logic [11:0] ctrlReg;
  logic [15:0] shadowReg;
  logic [3:0]  curChan;

  int checks = 0, errors = 0;
  int pwrErrCnt = 0, quietErrCnt = 0;
  bit done = 0;
  logic [15:0] expQ[$];
  logic [15:0] got;

  always #2.5 clk = ~clk;

  adc_serial_port #(.PWRUP_CYC(300), .QUIET_CYC(20)) u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .convResult(convResult), .dout(dout), .doutEn(doutEn), .holdOut(holdOut),
    .pwrReady(pwrReady), .pwrDown(pwrDown), .pwrErr(pwrErr), .quietErr(quietErr),
    .ctrlReg(ctrlReg), .shadowReg(shadowReg), .curChan(curChan)
  );

  always @(posedge clk) begin
    if (pwrErr)   pwrErrCnt++;
    if (quietErr) quietErrCnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mkCtrl(input bit wr, input bit seq, input logic [3:0] add,
      input logic [1:0] pm, input bit sh, input bit wk, input bit rg, input bit cd);
    return {wr, seq, add, pm, sh, wk, rg, cd, 4'b0000};
  endfunction

  task automatic doFrame(input logic [15:0] w, input logic [3:0] expChan,
                         input logic [11:0] res, input int gap);
    convResult = res;
    expQ.push_back({expChan, res});
    csN = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      din = w[15-i];
      if (i == 0)  chk("R1 hold at frame start", holdOut, 1);
      if (i == 13) chk("R5 hold before 14th edge", holdOut, 1);
      if (i == 14) chk("R5 track after 14th edge", holdOut, 0);
      sclk = 1'b1;
      repeat (6) @(negedge clk);
      sclk = 1'b0;
      repeat (6) @(negedge clk);
    end
    csN = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge csN);
      got = '0;
      for (int i = 0; i < 16; i++) begin
        @(posedge sclk);
        repeat (4) @(negedge clk);
        got[15-i] = dout;
        if (i == 0) chk("R6 driven in frame", doutEn, 1);
      end
      chk("R4 channel and result on dout", got, expQ.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    int pe, qe;
    rstN = 1'b0; csN = 1'b1; sclk = 1'b0; din = 1'b0; convResult = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk("R12 ready", pwrReady, 1);
    chk("R12 hold", holdOut, 0);
    chk("R12 doutEn", doutEn, 0);
    chk("R12 ctrl", ctrlReg, 12'h030);
    chk("R12 shadow", shadowReg, 0);
    chk("R12 chan", curChan, 0);

    w = mkCtrl(1, 0, 4'd5, 2'b11, 0, 0, 1, 0);
    doFrame(w, 4'd0, 12'hA5C, 30);
    chk("R2 ctrl written", ctrlReg, w[15:4]);
    chk("R6 released", doutEn, 0);

    doFrame(16'h7FF0, 4'd5, 12'h3C1, 30);
    chk("R2 no write keeps ctrl", ctrlReg, w[15:4]);
    chk("R11 direct address", curChan, 5);

    w = mkCtrl(1, 0, 4'd2, 2'b11, 1, 0, 0, 1);
    doFrame(w, 4'd5, 12'h0F0, 30);
    chk("R2 ctrl written arm", ctrlReg, w[15:4]);

    doFrame(16'h8482, 4'd2, 12'hFFF, 30);
    chk("R3 shadow loaded", shadowReg, 16'h8482);
    chk("R3 ctrl untouched", ctrlReg, w[15:4]);

    doFrame(mkCtrl(1, 1, 4'd0, 2'b11, 0, 0, 0, 0), 4'd2, 12'h123, 30);
    chk("R10 lowest enabled", curChan, 1);
    doFrame(16'h0000, 4'd1,  12'h456, 30);
    doFrame(16'h0000, 4'd7,  12'h789, 30);
    doFrame(16'h0000, 4'd10, 12'hABC, 30);
    doFrame(16'h0000, 4'd15, 12'hDEF, 30);
    chk("R10 wrap", curChan, 1);
    doFrame(16'h0000, 4'd1,  12'h001, 30);
    chk("R10 advance", curChan, 7);

    doFrame(mkCtrl(1, 0, 4'd3, 2'b11, 0, 1, 0, 0), 4'd7, 12'h800, 30);
    chk("R6 keep driving", doutEn, 1);
    doFrame(mkCtrl(1, 0, 4'd3, 2'b11, 0, 0, 0, 0), 4'd3, 12'h7FF, 30);
    chk("R6 release", doutEn, 0);
    chk("R9 no quiet error with gap", quietErrCnt, 0);

    w = mkCtrl(1, 0, 4'd3, 2'b10, 0, 0, 1, 1);
    doFrame(w, 4'd3, 12'h555, 30);
    chk("R7 down", pwrDown, 1);
    chk("R7 not ready", pwrReady, 0);
    chk("R7 ctrl retained", ctrlReg, w[15:4]);
    chk("R8 no error yet", pwrErrCnt, 0);

    doFrame(mkCtrl(1, 0, 4'd3, 2'b11, 0, 0, 0, 0), 4'd3, 12'hAAA, 30);
    chk("R8 waking not ready", pwrReady, 0);
    chk("R8 waking not down", pwrDown, 0);
    pe = pwrErrCnt;
    doFrame(16'h0000, 4'd3, 12'h111, 5);
    chk("R8 error during wake", (pwrErrCnt > pe), 1);
    qe = quietErrCnt;
    doFrame(16'h0000, 4'd3, 12'h222, 30);
    chk("R9 quiet violation", (quietErrCnt > qe), 1);
    repeat (400) @(negedge clk);
    chk("R8 ready after delay", pwrReady, 1);

    wait (expQ.size() == 0);
    repeat (10) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule